// File: doc/BRIEF.md
# Oscillator Frequency Trim Controller

This block is a sequencer that finds the trim setting of an on-chip resistor-capacitor oscillator. An 8-bit resistor code sets the frequency, which falls as the code rises. A 6-bit temperature-compensation code must follow the resistor code so that the compensation ratio stays fixed. A 2-bit capacitor code completes the trim word. On `start` the controller latches the capacitor code and a fixed-point compensation ratio. It then runs a bisection over the resistor code and asks an external frequency meter to judge each trial through a request/acknowledge handshake.

Each acknowledge carries a verdict: the oscillator ran slower than target, faster than target, or it dropped into its error state and raised a recovery reset. A reset verdict is taken to mean "too fast", because an over-fast setting is what breaks the two-phase charging. Alongside the verdict comes an unsigned error magnitude. When the bounds close, the controller picks the better of the lower bound and the last trial and holds that result together with `done`. For every resistor code it drives, the temperature code is recomputed as round((280 + code) * ratio / 88) - 6, clamped to the 6-bit range.

Top module: `trim_seq_ctrl`

## Requirements
- R1: After reset the block drives resistor code 128, temperature code 32, capacitor code 0, and holds `meas_req` and `done` low.
- R2: The first measurement of a run is taken at resistor code 0 to characterise the lower bound. Every later trial uses (low + high + 1) / 2, rounded down, which is the nearest integer to the mean with halves going up. The bounds start at 0 and 255.
- R3: After a trial the high bound takes the trial code when the trial was below target and the lower bound's last verdict was faster-than-target or reset. Otherwise the low bound takes the trial code and inherits that trial's verdict and error.
- R4: Verdict encoding on `meas_res`: 2'b00 below target, 2'b01 above target, 2'b10 error-state reset, 2'b11 handled as above target. A reset verdict counts as too fast, and its error magnitude is taken as all ones whatever `meas_err` carries.
- R5: The search stops once the high bound exceeds the low bound by exactly 1. The final resistor code is whichever of the low bound and the last trial has the smaller error. On equal error the lower code wins.
- R6: Whenever a resistor code other than the reset default is driven, including the final one, the temperature code equals round-half-up of (280 + code) * ratio / (88 * 256), minus 6, clamped to 0..63. The ratio is `alpha_in` with 8 fraction bits.
- R7: `meas_req` stays high with a stable resistor code until `meas_ack`. It falls in the cycle after the acknowledge, and each pair of requests is separated by at least one low cycle.
- R8: The capacitor code output is the value of `cap_in` latched at `start`. Changes on `cap_in` during or after a run have no effect on it.
- R9: `done` rises when the search ends and stays high, with the chosen codes held, until the next `start`. A `start` raised while a run is in progress is ignored.
- R10: The ratio is latched at `start`. Changes on `alpha_in` during a run do not alter any temperature code of that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a search (honoured only when idle or done) |
| alpha_in | input | 12 | Compensation ratio, unsigned, 8 fraction bits |
| cap_in | input | 2 | Capacitor code to apply for the run |
| meas_req | output | 1 | Request a frequency judgement of the driven codes |
| meas_ack | input | 1 | Judgement available this cycle |
| meas_res | input | 2 | Verdict: 00 below, 01 above, 10 reset, 11 above |
| meas_err | input | 16 | Unsigned frequency error magnitude |
| res_code | output | 8 | Resistor trim code |
| tmp_code | output | 6 | Temperature-compensation trim code |
| cap_code | output | 2 | Capacitor trim code |
| done | output | 1 | Search finished, codes final |

## Verification
The assertions watch the handshake shape and the search structure on every cycle. Requests hold until acknowledged and drop afterwards. The first probe sits at code 0 and every later trial lies strictly between the current bounds. The bounds stay ordered and are adjacent whenever `done` is high, and the capacitor code stays constant during a run. Some properties can only be shown by the bench scenarios, because they need an oscillator model: the exact order of trial codes under many target crossings, the handling of reset verdicts and of the spare encoding, the tie break toward the lower code, the arithmetic value of every temperature code, and the blocking of mid-run `start`, `alpha_in` and `cap_in` changes.

// File: rtl/trim_pkg.sv
package trim_pkg;

  typedef enum logic [1:0] {
    MR_BELOW = 2'b00,
    MR_ABOVE = 2'b01,
    MR_RESET = 2'b10,
    MR_SPARE = 2'b11
  } meas_res_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROBE,
    ST_TRIAL,
    ST_STEP,
    ST_DONE
  } seq_state_e;

  // nearest integer to the mean of two bounds, halves rounded up
  function automatic int unsigned nearest_mid(int unsigned lo, int unsigned hi);
    return (lo + hi + 32'd1) >> 1;
  endfunction

  // temperature code from resistor code and fixed-point ratio
  function automatic int unsigned tcode_calc(
    int unsigned wt, int unsigned alpha,
    int unsigned kb, int unsigned kc, int unsigned ka,
    int unsigned frac, int unsigned tmax);
    logic [63:0] num;
    logic [63:0] den;
    logic [63:0] q;
    num = 64'(kb + wt) * 64'(alpha);
    den = 64'(kc) << frac;
    q   = (num + (den >> 1)) / den;
    if (q <= 64'(ka)) return 32'd0;
    if ((q - 64'(ka)) > 64'(tmax)) return tmax;
    return 32'(q - 64'(ka));
  endfunction

endpackage

// File: rtl/trim_tcode_map.sv
module trim_tcode_map #(
  parameter int RW = 8,
  parameter int TW = 6,
  parameter int AW = 12,
  parameter int unsigned AF = 8,
  parameter int unsigned KA = 6,
  parameter int unsigned KB = 280,
  parameter int unsigned KC = 88
)(
  input  logic [RW-1:0] res_code,
  input  logic [AW-1:0] alpha,
  output logic [TW-1:0] tmp_code
);
  localparam int unsigned TMAX = (32'd1 << TW) - 32'd1;

  assign tmp_code = TW'(trim_pkg::tcode_calc(32'(res_code), 32'(alpha),
                                             KB, KC, KA, AF, TMAX));
endmodule

// File: rtl/trim_bisect_core.sv
module trim_bisect_core #(
  parameter int RW = 8,
  parameter int EW = 16
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init,
  input  logic          probe_ld,
  input  logic          trial_ld,
  input  logic [RW-1:0] trial_code,
  input  logic          res_fast,
  input  logic [EW-1:0] res_err,
  output logic [RW-1:0] lo_bnd,
  output logic [RW-1:0] hi_bnd,
  output logic [RW-1:0] last_code,
  output logic [EW-1:0] lo_err,
  output logic [EW-1:0] last_err,
  output logic          lo_fast,
  output logic          adjacent,
  output logic [RW-1:0] next_trial
);
  logic move_hi;

  // trial was slow and the low side is known fast: shrink from above
  assign move_hi    = trial_ld && !res_fast && lo_fast;
  assign adjacent   = (hi_bnd - lo_bnd) == RW'(1);
  assign next_trial = RW'(trim_pkg::nearest_mid(32'(lo_bnd), 32'(hi_bnd)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_bnd    <= '0;
      hi_bnd    <= '1;
      last_code <= '0;
      lo_err    <= '1;
      last_err  <= '1;
      lo_fast   <= 1'b0;
    end else if (init) begin
      lo_bnd    <= '0;
      hi_bnd    <= '1;
      last_code <= '0;
      lo_err    <= '1;
      last_err  <= '1;
      lo_fast   <= 1'b0;
    end else if (probe_ld) begin
      lo_fast   <= res_fast;
      lo_err    <= res_err;
      last_code <= '0;
      last_err  <= res_err;
    end else if (trial_ld) begin
      last_code <= trial_code;
      last_err  <= res_err;
      if (move_hi) begin
        hi_bnd <= trial_code;
      end else begin
        lo_bnd  <= trial_code;
        lo_fast <= res_fast;
        lo_err  <= res_err;
      end
    end
  end
endmodule

// File: rtl/trim_pick.sv
module trim_pick #(
  parameter int RW = 8,
  parameter int EW = 16
)(
  input  logic [RW-1:0] lo_bnd,
  input  logic [EW-1:0] lo_err,
  input  logic [RW-1:0] last_code,
  input  logic [EW-1:0] last_err,
  output logic [RW-1:0] pick_code
);
  logic last_better;
  logic lo_better;
  logic tie_low;

  assign last_better = last_err < lo_err;
  assign lo_better   = lo_err < last_err;
  assign tie_low     = (last_code < lo_bnd);

  always_comb begin
    if (last_better)    pick_code = last_code;
    else if (lo_better) pick_code = lo_bnd;
    else if (tie_low)   pick_code = last_code;
    else                pick_code = lo_bnd;
  end
endmodule

// File: rtl/trim_seq_ctrl.sv
module trim_seq_ctrl
  import trim_pkg::*;
#(
  parameter int RW = 8,
  parameter int TW = 6,
  parameter int CW = 2,
  parameter int AW = 12,
  parameter int unsigned AF = 8,
  parameter int EW = 16,
  parameter int unsigned KA = 6,
  parameter int unsigned KB = 280,
  parameter int unsigned KC = 88,
  parameter int unsigned INIT_R = 128,
  parameter int unsigned INIT_T = 32
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] alpha_in,
  input  logic [CW-1:0] cap_in,
  output logic          meas_req,
  input  logic          meas_ack,
  input  logic [1:0]    meas_res,
  input  logic [EW-1:0] meas_err,
  output logic [RW-1:0] res_code,
  output logic [TW-1:0] tmp_code,
  output logic [CW-1:0] cap_code,
  output logic          done
);
  seq_state_e    st_q, st_d;
  logic [RW-1:0] cur_q, fin_q;
  logic [AW-1:0] alpha_q;
  logic [CW-1:0] cap_q;

  // named internal events (also observed by the bound checker)
  logic          launch, probe_done, trial_done, finish_evt;
  logic          run_active, probe_phase;
  logic          res_fast;
  logic [EW-1:0] res_err;

  logic [RW-1:0] lo_bnd, hi_bnd, last_code, next_trial, pick_code;
  logic [EW-1:0] lo_err, last_err;
  logic          lo_fast, adjacent;
  logic [TW-1:0] tc_live;

  assign launch      = start && (st_q == ST_IDLE || st_q == ST_DONE);
  assign probe_done  = (st_q == ST_PROBE) && meas_ack;
  assign trial_done  = (st_q == ST_TRIAL) && meas_ack;
  assign finish_evt  = (st_q == ST_STEP) && adjacent;
  assign run_active  = (st_q == ST_PROBE) || (st_q == ST_TRIAL) || (st_q == ST_STEP);
  assign probe_phase = (st_q == ST_PROBE);
  assign res_fast    = (meas_res != MR_BELOW);
  assign res_err     = (meas_res == MR_RESET) ? '1 : meas_err;

  trim_bisect_core #(.RW(RW), .EW(EW)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .init       (launch),
    .probe_ld   (probe_done),
    .trial_ld   (trial_done),
    .trial_code (cur_q),
    .res_fast   (res_fast),
    .res_err    (res_err),
    .lo_bnd     (lo_bnd),
    .hi_bnd     (hi_bnd),
    .last_code  (last_code),
    .lo_err     (lo_err),
    .last_err   (last_err),
    .lo_fast    (lo_fast),
    .adjacent   (adjacent),
    .next_trial (next_trial)
  );

  trim_pick #(.RW(RW), .EW(EW)) u_pick (
    .lo_bnd    (lo_bnd),
    .lo_err    (lo_err),
    .last_code (last_code),
    .last_err  (last_err),
    .pick_code (pick_code)
  );

  trim_tcode_map #(
    .RW(RW), .TW(TW), .AW(AW), .AF(AF), .KA(KA), .KB(KB), .KC(KC)
  ) u_tmap (
    .res_code (res_code),
    .alpha    (alpha_q),
    .tmp_code (tc_live)
  );

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:  if (launch)     st_d = ST_PROBE;
      ST_PROBE: if (meas_ack)   st_d = ST_STEP;
      ST_TRIAL: if (meas_ack)   st_d = ST_STEP;
      ST_STEP:  st_d = adjacent ? ST_DONE : ST_TRIAL;
      ST_DONE:  if (launch)     st_d = ST_PROBE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cur_q   <= '0;
      fin_q   <= RW'(INIT_R);
      alpha_q <= '0;
      cap_q   <= '0;
    end else begin
      st_q <= st_d;
      if (launch) begin
        cur_q   <= '0;
        alpha_q <= alpha_in;
        cap_q   <= cap_in;
      end else if ((st_q == ST_STEP) && !adjacent) begin
        cur_q <= next_trial;
      end
      if (finish_evt) fin_q <= pick_code;
    end
  end

  always_comb begin
    case (st_q)
      ST_IDLE: res_code = RW'(INIT_R);
      ST_DONE: res_code = fin_q;
      default: res_code = cur_q;
    endcase
  end

  assign tmp_code = (st_q == ST_IDLE) ? TW'(INIT_T) : tc_live;
  assign cap_code = cap_q;
  assign meas_req = (st_q == ST_PROBE) || (st_q == ST_TRIAL);
  assign done     = (st_q == ST_DONE);

endmodule

// File: rtl/trim_seq_chk.sv
module trim_seq_chk #(
  parameter int RW = 8,
  parameter int CW = 2
)(
  input logic          clk,
  input logic          rst_n,
  input logic          meas_req,
  input logic          meas_ack,
  input logic          done,
  input logic          run_active,
  input logic          probe_phase,
  input logic [RW-1:0] res_code,
  input logic [RW-1:0] lo_bnd,
  input logic [RW-1:0] hi_bnd,
  input logic [CW-1:0] cap_code
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    meas_req && !meas_ack |=> meas_req && $stable(res_code)); // R7
  AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    meas_req && meas_ack |=> !meas_req); // R7
  AST_PROBE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    meas_req && probe_phase |-> res_code == '0); // R2
  AST_TRIAL_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    meas_req && !probe_phase |-> (res_code > lo_bnd) && (res_code < hi_bnd)); // R2
  AST_BOUND_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    run_active |-> lo_bnd < hi_bnd); // R3
  AST_DONE_ADJ: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (hi_bnd - lo_bnd) == RW'(1)); // R5
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !meas_req); // R9
  AST_CAP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    run_active && $past(run_active) |-> $stable(cap_code)); // R8
endmodule

bind trim_seq_ctrl trim_seq_chk #(.RW(RW), .CW(CW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .meas_req    (meas_req),
  .meas_ack    (meas_ack),
  .done        (done),
  .run_active  (run_active),
  .probe_phase (probe_phase),
  .res_code    (res_code),
  .lo_bnd      (lo_bnd),
  .hi_bnd      (hi_bnd),
  .cap_code    (cap_code)
);

// File: tb/sim_trim_seq_ctrl.sv
module sim_trim_seq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [11:0] alpha_in = '0;
  logic [1:0]  cap_in = '0;
  logic        meas_req;
  logic        meas_ack = 1'b0;
  logic [1:0]  meas_res = 2'b00;
  logic [15:0] meas_err = '0;
  logic [7:0]  res_code;
  logic [5:0]  tmp_code;
  logic [1:0]  cap_code;
  logic        done;

  int n_chk = 0;
  int n_err = 0;
  int thr_g, tgt_g;
  bit use_spare;
  int exp_seq [0:15];

  always #5 clk = ~clk;

  trim_seq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .alpha_in(alpha_in), .cap_in(cap_in),
    .meas_req(meas_req), .meas_ack(meas_ack), .meas_res(meas_res), .meas_err(meas_err),
    .res_code(res_code), .tmp_code(tmp_code), .cap_code(cap_code), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // oscillator model: frequency falls by 6 per code step
  function automatic int freq(int code);
    return 3000 - 6 * code;
  endfunction
  function automatic bit m_fast(int code);
    return (code < thr_g) || (freq(code) >= tgt_g);
  endfunction
  function automatic int m_err(int code);
    int d;
    if (code < thr_g) return 65535;
    d = freq(code) - tgt_g;
    return (d < 0) ? -d : d;
  endfunction

  // temperature code restated: round half up via doubled numerator
  function automatic int t_exp(int wt, int a);
    int q;
    q = (2 * (280 + wt) * a + 88 * 256) / (2 * 88 * 256) - 6;
    if (q < 0) q = 0;
    if (q > 63) q = 63;
    return q;
  endfunction

  task automatic model(output int n, output int fin);
    int lo, hi, le, m, last, lst_e;
    bit lf;
    exp_seq[0] = 0; n = 1;
    lo = 0; hi = 255; lf = m_fast(0); le = m_err(0); last = 0; lst_e = le;
    while (hi - lo > 1) begin
      m = lo + (hi - lo + 1) / 2;
      exp_seq[n] = m; n++;
      if (!m_fast(m) && lf) hi = m;
      else begin lo = m; lf = m_fast(m); le = m_err(m); end
      last = m; lst_e = m_err(m);
    end
    if (lst_e < le) fin = last;
    else if (le < lst_e) fin = lo;
    else fin = (last < lo) ? last : lo;
  endtask

  task automatic run_one(input int thr, input int tgt, input int a, input int cap,
                         input bit spare, input bit poke);
    int n, fin, idx, lat, code, guard;
    thr_g = thr; tgt_g = tgt; use_spare = spare;
    model(n, fin);
    alpha_in = 12'(a); cap_in = 2'(cap); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    alpha_in = 12'(a ^ 12'h5A5); // R10: must not take effect
    cap_in = 2'(~cap);          // R8: must not take effect
    idx = 0; lat = 0; guard = 0;
    while (!done && guard < 500) begin
      guard++;
      if (meas_req) begin
        code = int'(res_code);
        if (idx < n) chk(code == exp_seq[idx], "R2/R3 trial code", code, exp_seq[idx]);
        else chk(0, "R5 extra trial", idx, n);
        chk(int'(tmp_code) == t_exp(code, a), "R6 trial temp code", int'(tmp_code), t_exp(code, a));
        chk(int'(cap_code) == cap, "R8 cap held", int'(cap_code), cap);
        repeat (lat) @(negedge clk);
        meas_ack = 1'b1;
        if (code < thr) begin meas_res = 2'b10; meas_err = 16'd1; end       // R4
        else if (freq(code) >= tgt) begin
          meas_res = spare ? 2'b11 : 2'b01; meas_err = 16'(m_err(code));
        end else begin meas_res = 2'b00; meas_err = 16'(m_err(code)); end
        if (poke && idx == 2) start = 1'b1;                               // R9
        @(negedge clk);
        meas_ack = 1'b0; start = 1'b0;
        chk(!meas_req, "R7 req drop", int'(meas_req), 0);
        idx++;
        lat = (lat + 1) % 3;
      end else @(negedge clk);
    end
    chk(idx == n, "R5 trial count", idx, n);
    chk(done, "R9 done", int'(done), 1);
    chk(int'(res_code) == fin, "R5 final code", int'(res_code), fin);
    chk(int'(tmp_code) == t_exp(fin, a), "R6 final temp code", int'(tmp_code), t_exp(fin, a));
    repeat (3) @(negedge clk);
    chk(done && int'(res_code) == fin, "R9 held", int'(res_code), fin);
    chk(int'(cap_code) == cap, "R8 cap after done", int'(cap_code), cap);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int alphas [3] = '{0, 2096, 4095};
    int sel;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(int'(res_code) == 128, "R1 reset res", int'(res_code), 128);
    chk(int'(tmp_code) == 32, "R1 reset tmp", int'(tmp_code), 32);
    chk(int'(cap_code) == 0, "R1 reset cap", int'(cap_code), 0);
    chk(!meas_req && !done, "R1 reset req/done", int'({meas_req, done}), 0);
    sel = 0;
    for (int k = 0; k < 256; k += 15) begin
      for (int off = 0; off < 4; off++) begin
        for (int tm = 0; tm < 2; tm++) begin
          run_one(tm ? ((k + 1 > 200) ? 200 : k + 1) : 0,
                  freq(k) - off, alphas[sel % 3], sel % 4,
                  (sel % 5) == 0, (sel % 3) == 1);
          sel++;
        end
      end
    end
    run_one(0, 5000, 2096, 1, 0, 0);   // every code slow
    run_one(0, 0, 4095, 2, 1, 1);      // every code fast
    run_one(255, 1000, 0, 3, 0, 0);    // R4: every code resets
    run_one(100, 2380, 2096, 0, 0, 0); // R4: crossing beside reset zone
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule